// File: doc/BRIEF.md
# PHY Reset Release Sequencer

This block owns the active-low reset line of an external Ethernet PHY. When asked to start, it first waits until both the supply-good and reference-clock-present inputs are high. It then keeps the reset line low for a hold interval with its output driver switched off, so the board pull-down supplies the low level. Next it preloads a high output value and only then turns the driver on, which produces the first rising edge.

In managed mode that single rising edge ends the release. In unmanaged mode the line stays high for one short gap, is driven low for a short pulse of the same length, and is driven high again, so the PHY sees exactly two rising edges. In both modes a settle interval follows the last rising edge. After it, a ready flag goes high, and that flag gates any management-register access.

All intervals are given in nanoseconds together with the clock frequency. Each one becomes a whole number of clock cycles, rounded up and never less than one. Once an unmanaged release has completed, the block never produces a single-edge release again until the system reset.

Top module: `phy_rstseq`

## Requirements
- R1: While and just after the synchronous system reset (`rst_ni` low), `phy_rst_oe` is 0, `phy_rst_n` is 1, `ready` is 0 and `busy` is 0.
- R2: After `start`, `busy` is 1, and the driver stays off (the line held low by the pull-down) for as long as either `pwr_good` or `refclk_ok` is low. A driver turn-on only follows a cycle in which both were high.
- R3: Before the first rising edge, the line is low for at least ceil(HOLD_NS·CLK_HZ/1e9) cycles, and during that time `phy_rst_oe` is 0.
- R4: Whenever `phy_rst_oe` rises, `phy_rst_n` was already 1 in the previous cycle and is still 1, so turning the driver on never produces a low glitch.
- R5: With `unmanaged_mode` = 0 at start, the line (low when `phy_rst_oe` = 0, otherwise `phy_rst_n`) shows exactly one rising edge per release.
- R6: With `unmanaged_mode` = 1 at start, the line shows exactly two rising edges. The high gap between them and the low pulse each last ceil(GAP_NS·CLK_HZ/1e9) cycles; with 90 ns at 50 MHz that is 5 cycles.
- R7: `ready` rises exactly ceil(SETTLE_NS·CLK_HZ/1e9) cycles after the last rising edge. While `ready` is 1, the driver is on, the line is high and `busy` is 0.
- R8: A `start` pulse while `busy` is 1 is ignored, including its `unmanaged_mode` value. The release under way completes with its original edge count and produces one `ready` rise.
- R9: A `start` pulse while `ready` is 1 clears `ready` in the next cycle and runs the full sequence again.
- R10: After an unmanaged release has completed, every later release produces two rising edges whatever `unmanaged_mode` is. Only the system reset clears this.
- R11: If `pwr_good` or `refclk_ok` drops while `busy` is 1, then in the next cycle the driver is off and `ready` is 0. The sequence restarts from the hold interval once both inputs are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_ni | input | 1 | Synchronous active-low system reset |
| pwr_good | input | 1 | PHY supply is within range |
| refclk_ok | input | 1 | PHY reference clock is running |
| start | input | 1 | One-cycle request to run a release sequence |
| unmanaged_mode | input | 1 | Sampled with `start`: 1 selects two rising edges |
| phy_rst_n | output | 1 | Output value of the PHY reset pin (active low) |
| phy_rst_oe | output | 1 | Output enable of the PHY reset pin; 0 leaves it to the pull-down |
| ready | output | 1 | Settle time elapsed; register access allowed |
| busy | output | 1 | A release sequence is in progress |

## Verification
Releases are run in both modes, and each comparison pins down something different:
- A managed run against an unmanaged run separates one rising edge from two. The gap and pulse widths are measured as well, at a period that needs rounding up.
- A managed request issued after an unmanaged completion shows whether the mode latch holds. The same request after a system reset shows that the latch clears.
- A start given while the supplies are still missing must not release the line.
- A second start with a flipped mode, given mid-sequence, must not change the edge count or add a second ready.
- A clock loss inside the hold interval must push the pin back to its pull-down state. The release must then still finish with the right edge count.

// File: rtl/phy_rstseq_pkg.sv
// Shared types and interval helper for the PHY reset sequencer.
// Assumes all timing inputs are given in nanoseconds and hertz.
package phy_rstseq_pkg;

    // Sequencer states; order has no behavioural meaning.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_ARM,
        ST_HIGH,
        ST_LOW,
        ST_SETTLE,
        ST_READY
    } seq_state_t;

    // Converts a duration to clock cycles, rounding up, at least one.
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        longint unsigned cyc;
        cyc = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 64'd0) begin
            cyc = 64'd1;
        end
        return cyc;
    endfunction

endpackage

// File: rtl/phy_rstseq_timer.sv
// Interval counter: restarts from zero when told and reports when the
// current interval limit (given minus one) has been reached.
// Assumes the caller clears it on every state change.
module phy_rstseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles spent in the current state.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == limit_m1);

endmodule

// File: rtl/phy_rstseq_pins.sv
// Output decode: maps the sequencer state onto the pin value, pin
// enable and the two status flags. Purely combinational from a
// registered state, so outputs change only after a clock edge.
module phy_rstseq_pins
    import phy_rstseq_pkg::*;
(
    input  seq_state_t state,
    output logic       pin_val,
    output logic       pin_oe,
    output logic       ready,
    output logic       busy
);

    // Derives each output from the current state.
    always_comb begin
        pin_oe  = 1'b0;
        pin_val = 1'b0;
        ready   = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:   begin pin_val = 1'b1; busy = 1'b0; end
            ST_WAIT:   ;
            ST_HOLD:   ;
            ST_ARM:    pin_val = 1'b1;
            ST_HIGH:   begin pin_val = 1'b1; pin_oe = 1'b1; end
            ST_LOW:    pin_oe = 1'b1;
            ST_SETTLE: begin pin_val = 1'b1; pin_oe = 1'b1; end
            ST_READY:  begin pin_val = 1'b1; pin_oe = 1'b1; ready = 1'b1; busy = 1'b0; end
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/phy_rstseq.sv
// PHY reset release sequencer (top). Waits for supplies and reference
// clock, holds reset low through the pull-down, preloads a high value
// before enabling the driver, optionally adds a second low pulse, then
// waits a settle time and raises ready. Assumes an external pull-down
// on the reset pin and synchronous inputs.
module phy_rstseq
    import phy_rstseq_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 50_000_000,
    parameter longint unsigned HOLD_NS   = 2_000_000,
    parameter longint unsigned GAP_NS    = 100,
    parameter longint unsigned SETTLE_NS = 15_000_000
) (
    input  logic clk,
    input  logic rst_ni,
    input  logic pwr_good,
    input  logic refclk_ok,
    input  logic start,
    input  logic unmanaged_mode,
    output logic phy_rst_n,
    output logic phy_rst_oe,
    output logic ready,
    output logic busy
);

    localparam longint unsigned HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam longint unsigned GAP_CYC    = ns_to_cycles(GAP_NS, CLK_HZ);
    localparam longint unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_HZ);
    localparam longint unsigned MAX_A      = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam longint unsigned MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int              CNT_W      = $clog2(MAX_CYC + 64'd1);
    localparam logic [CNT_W-1:0] HOLD_M1   = CNT_W'(HOLD_CYC - 64'd1);
    localparam logic [CNT_W-1:0] GAP_M1    = CNT_W'(GAP_CYC - 64'd1);
    localparam logic [CNT_W-1:0] SETTLE_M1 = CNT_W'(SETTLE_CYC - 64'd1);

    seq_state_t       state_q, state_d;
    logic             two_edges_q;
    logic             locked_q;
    logic             supplies_ok;
    logic             take_start;
    logic             expired;
    logic [CNT_W-1:0] limit_m1;

    assign supplies_ok = pwr_good & refclk_ok;
    assign take_start  = start & ((state_q == ST_IDLE) | (state_q == ST_READY));

    // Chooses the length of the timed state currently active.
    always_comb begin
        unique case (state_q)
            ST_HOLD:         limit_m1 = HOLD_M1;
            ST_HIGH, ST_LOW: limit_m1 = GAP_M1;
            default:         limit_m1 = SETTLE_M1;
        endcase
    end

    // Next-state logic, including abort on supply or clock loss.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_WAIT;
            ST_WAIT:   if (supplies_ok) state_d = ST_HOLD;
            ST_HOLD:   if (!supplies_ok) state_d = ST_WAIT;
                       else if (expired) state_d = ST_ARM;
            ST_ARM:    if (!supplies_ok) state_d = ST_WAIT;
                       else state_d = two_edges_q ? ST_HIGH : ST_SETTLE;
            ST_HIGH:   if (!supplies_ok) state_d = ST_WAIT;
                       else if (expired) state_d = ST_LOW;
            ST_LOW:    if (!supplies_ok) state_d = ST_WAIT;
                       else if (expired) state_d = ST_SETTLE;
            ST_SETTLE: if (!supplies_ok) state_d = ST_WAIT;
                       else if (expired) state_d = ST_READY;
            ST_READY:  if (start) state_d = ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Samples the mode at an accepted start; a prior unmanaged release forces two edges.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            two_edges_q <= 1'b0;
        end else if (take_start) begin
            two_edges_q <= unmanaged_mode | locked_q;
        end
    end

    // Remembers that an unmanaged release has completed.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            locked_q <= 1'b0;
        end else if ((state_q == ST_SETTLE) && (state_d == ST_READY) && two_edges_q) begin
            locked_q <= 1'b1;
        end
    end

    phy_rstseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .clear    (state_d != state_q),
        .limit_m1 (limit_m1),
        .expired  (expired)
    );

    phy_rstseq_pins u_pins (
        .state   (state_q),
        .pin_val (phy_rst_n),
        .pin_oe  (phy_rst_oe),
        .ready   (ready),
        .busy    (busy)
    );

endmodule

// File: rtl/phy_rstseq_chk.sv
// Port-level property checker for the PHY reset sequencer, bound to
// every instance of the top module. Assumes a synchronous reset.
module phy_rstseq_chk (
    input logic clk,
    input logic rst_ni,
    input logic pwr_good,
    input logic refclk_ok,
    input logic start,
    input logic phy_rst_n,
    input logic phy_rst_oe,
    input logic ready,
    input logic busy
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!phy_rst_oe && phy_rst_n && !ready && !busy));

    assert_enable_needs_supplies_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(phy_rst_oe) |-> $past(pwr_good && refclk_ok));

    assert_no_enable_glitch_R4: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(phy_rst_oe) |-> ($past(phy_rst_n) && phy_rst_n));

    assert_ready_pin_high_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        ready |-> (phy_rst_oe && phy_rst_n && !busy));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        (ready && start) |=> (!ready && busy));

    assert_abort_releases_R11: assert property (@(posedge clk) disable iff (!rst_ni)
        (busy && !(pwr_good && refclk_ok)) |=> (!phy_rst_oe && !ready));

endmodule

bind phy_rstseq phy_rstseq_chk u_chk (.*);

// File: tb/sim_phy_rstseq.sv
// Scoreboard bench: driver tasks queue the expected edge count of each
// release, a negedge monitor measures the pin and pops on each ready rise.
module sim_phy_rstseq;

    localparam longint unsigned HZ    = 50_000_000;
    localparam longint unsigned T_HLD = 400;
    localparam longint unsigned T_GAP = 90;
    localparam longint unsigned T_SET = 1000;
    localparam int EXP_H = int'((T_HLD * HZ + 64'd999_999_999) / 64'd1_000_000_000);
    localparam int EXP_G = int'((T_GAP * HZ + 64'd999_999_999) / 64'd1_000_000_000);
    localparam int EXP_S = int'((T_SET * HZ + 64'd999_999_999) / 64'd1_000_000_000);

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic pwr_good = 1'b0;
    logic refclk_ok = 1'b0;
    logic start = 1'b0;
    logic unmanaged_mode = 1'b0;
    logic phy_rst_n, phy_rst_oe, ready, busy;
    logic pin;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];

    int edges = 0, run = 0, first_low = 0, high_w = 0, low_w = 0, rise_cyc = 0;
    logic prev_pin = 1'b0, prev_ready = 1'b0, prev_oe = 1'b0, prev_val = 1'b1;

    always #10 clk = ~clk;

    assign pin = phy_rst_oe ? phy_rst_n : 1'b0;

    phy_rstseq #(
        .CLK_HZ    (HZ),
        .HOLD_NS   (T_HLD),
        .GAP_NS    (T_GAP),
        .SETTLE_NS (T_SET)
    ) u0 (
        .clk            (clk),
        .rst_ni         (rst_ni),
        .pwr_good       (pwr_good),
        .refclk_ok      (refclk_ok),
        .start          (start),
        .unmanaged_mode (unmanaged_mode),
        .phy_rst_n      (phy_rst_n),
        .phy_rst_oe     (phy_rst_oe),
        .ready          (ready),
        .busy           (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measures pin levels and compares against the scoreboard.
    always @(negedge clk) begin
        cyc++;
        if (!rst_ni) begin
            edges = 0; run = 0; prev_pin = 1'b0; prev_ready = 1'b0;
            prev_oe = 1'b0; prev_val = 1'b1;
        end else begin
            if (pin == prev_pin) begin
                run++;
            end else begin
                if (pin) begin
                    if (edges == 0) first_low = run; else low_w = run;
                    edges++;
                    rise_cyc = cyc;
                end else if (edges == 1) begin
                    high_w = run;
                end
                run = 1;
            end
            if (phy_rst_oe && !prev_oe) begin
                chk(prev_val && phy_rst_n, "R4 value high around enable", int'(prev_val), 1);
            end
            if (ready && !prev_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected ready rise", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(edges == e, (e == 1) ? "R5 rising edges" : "R6 rising edges", edges, e);
                    chk(cyc - rise_cyc == EXP_S, "R7 settle cycles", cyc - rise_cyc, EXP_S);
                    chk(first_low >= EXP_H, "R3 hold cycles", first_low, EXP_H);
                    if (e == 2) begin
                        chk(high_w == EXP_G, "R6 high gap", high_w, EXP_G);
                        chk(low_w == EXP_G, "R6 low pulse", low_w, EXP_G);
                    end
                end
                edges = 0;
            end
            prev_pin = pin; prev_ready = ready; prev_oe = phy_rst_oe; prev_val = phy_rst_n;
        end
    end

    // Driver: queues the expected edge count and pulses start.
    task automatic run_seq(input bit mode, input int exp_edges);
        bit was_rdy;
        @(negedge clk);
        exp_q.push_back(exp_edges);
        unmanaged_mode = mode;
        was_rdy = ready;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (was_rdy) chk(!ready && busy, "R9 restart clears ready", int'(ready), 0);
        else         chk(busy, "R2 busy after start", int'(busy), 1);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (ready) break;
        end
        chk(ready, "R7 ready reached", int'(ready), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        chk(!phy_rst_oe && phy_rst_n && !ready && !busy, "R1 reset outputs",
            {28'd0, phy_rst_oe, phy_rst_n, ready, busy}, 4);
        rst_ni = 1'b1;
        @(negedge clk);
        chk(!phy_rst_oe && phy_rst_n && !ready && !busy, "R1 after reset release",
            {28'd0, phy_rst_oe, phy_rst_n, ready, busy}, 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R2: no release while supplies are missing.
        run_seq(1'b0, 1);
        repeat (30) @(negedge clk);
        chk(!phy_rst_oe && !pin && !ready && busy, "R2 held without supplies", int'(phy_rst_oe), 0);
        pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        chk(!phy_rst_oe && !pin, "R2 held without refclk", int'(phy_rst_oe), 0);
        refclk_ok = 1'b1;
        wait_ready();

        // R9 and R5: restart from ready in managed mode.
        run_seq(1'b0, 1);
        wait_ready();

        // R6: unmanaged release.
        run_seq(1'b1, 2);
        wait_ready();

        // R10: managed request after an unmanaged completion still gives two edges.
        run_seq(1'b0, 2);
        wait_ready();

        // R10: system reset clears the latch, managed gives one edge again.
        do_reset();
        run_seq(1'b0, 1);
        // R8: start with flipped mode while busy is ignored.
        repeat (10) @(negedge clk);
        unmanaged_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_ready();
        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0 && ready, "R8 single ready for ignored start", exp_q.size(), 0);

        // R11: clock loss inside the hold interval.
        run_seq(1'b1, 2);
        repeat (8) @(negedge clk);
        refclk_ok = 1'b0;
        repeat (10) @(negedge clk);
        chk(!phy_rst_oe && !pin && !ready && busy, "R11 abort to pull-down", int'(phy_rst_oe), 0);
        refclk_ok = 1'b1;
        wait_ready();
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all releases seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule